// File: doc/BRIEF.md
# Ambiguity-Surface Sweep Controller

This block builds a lag-by-offset grid of cross-ambiguity values. A reference burst of `REF_LEN` complex samples and a captured burst of exactly `2*REF_LEN` complex samples are written through two load ports. A table of `NUM_OFFSETS` signed phase increments is written through a third port. A single-cycle `start` pulse then launches a sweep.

For each table entry, in table order, the block frequency-shifts the captured samples with a quarter-turn rotator. The rotator is driven by the phase `n*inc`. The block then correlates the shifted capture against the conjugated reference at `REF_LEN` lags, from `-REF_LEN/2` up to `REF_LEN/2-1`. Each lag is a dot product of `REF_LEN` terms, and the dot product is pipelined so that one term is accumulated per cycle. Lags within a sweep therefore complete back to back.

Each result leaves on a stream that carries the offset index, the signed lag and the squared magnitude I²+Q² of the complex correlation. A one-cycle `done` pulse closes the sweep.

Top module: `amb_sweep_ctrl`

## Requirements
- R1: After reset, and until a start is accepted, `res_valid` and `done` stay low.
- R2: A sweep emits exactly `REF_LEN*NUM_OFFSETS` results. The offset index is the outer loop and follows table order. The lag is the inner loop and ascends. `res_off` is the table index.
- R3: `res_lag` is a two's-complement value equal to the lag index minus `REF_LEN/2`, so it runs from `-REF_LEN/2` to `REF_LEN/2-1`.
- R4: For offset `o` and lag index `m`, the correlation is the sum over `k = 0..REF_LEN-1` of `conj(ref[k]) * s[k+m]`, where `s` is the shifted capture. Capture addresses therefore run from 0 to `2*REF_LEN-2`.
- R5: The shifted capture is `s[n] = cap[n]` rotated counterclockwise by `q` quarter turns. Here `q` is the top two bits of `(n*inc[o]) mod 2^PHASE_W`. For `q=1`, the pair (i,q) becomes (-q,i). The rotation is exact, with no overflow at the most negative sample value.
- R6: `res_mag` equals I²+Q² of the correlation sum, computed at full precision with no rounding or saturation.
- R7: Offset table entries are `PHASE_W`-bit two's-complement increments. A negative entry rotates clockwise, through the same modular phase arithmetic.
- R8: `done` is high for exactly one cycle: the cycle right after the last result of the sweep.
- R9: A `start` pulse received while a sweep is in progress is ignored. The sweep continues unchanged, and no further results follow its `done`.
- R10: Within a sweep, consecutive results are exactly `REF_LEN` cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_we | input | 1 | Reference sample write enable |
| ref_waddr | input | LAG_W | Reference sample index |
| ref_wi | input | SAMP_W | Reference in-phase component, signed |
| ref_wq | input | SAMP_W | Reference quadrature component, signed |
| cap_we | input | 1 | Captured sample write enable |
| cap_waddr | input | LAG_W+1 | Captured sample index (0..2*REF_LEN-1) |
| cap_wi | input | SAMP_W | Captured in-phase component, signed |
| cap_wq | input | SAMP_W | Captured quadrature component, signed |
| off_we | input | 1 | Offset table write enable |
| off_waddr | input | OFF_W | Offset table index |
| off_winc | input | PHASE_W | Signed phase increment per sample |
| start | input | 1 | Launch a sweep when idle |
| res_valid | output | 1 | Result stream valid |
| res_off | output | OFF_W | Offset index of the result |
| res_lag | output | LAG_W | Signed lag of the result |
| res_mag | output | MAG_W | Squared correlation magnitude |
| done | output | 1 | One-cycle end-of-sweep pulse |

## Verification
The bench builds the block with `REF_LEN=8`, `NUM_OFFSETS=4`, `SAMP_W=6` and `PHASE_W=4`. With this configuration every lag of every offset, 32 results per sweep, is compared against a sum computed in the bench, and the top quadrant bit of the phase wraps many times inside one capture. The sample generator sweeps the whole signed range, including -32, so the rotator's negation edge is exercised. Two tables, one with increments of ±4 (whole quarter turns) and one with odd and negative increments, cover both rotation directions. The second sweep carries a start pulse in mid-flight.

// File: rtl/amb_sweep_pkg.sv
package amb_sweep_pkg;

    localparam int QUAD_W = 2;

    typedef enum logic [1:0] {
        SW_IDLE  = 2'd0,
        SW_RUN   = 2'd1,
        SW_DRAIN = 2'd2
    } sweep_state_e;

    // control word travelling with every dot-product term
    typedef struct packed {
        logic              vld;
        logic              first;   // first term of a lag
        logic              last;    // last term of a lag
        logic              fin;     // last term of the whole sweep
        logic [QUAD_W-1:0] quad;    // quarter turns applied to the capture sample
    } mac_ctl_t;

    function automatic int clog2_min1(input int v);
        return (v > 1) ? $clog2(v) : 1;
    endfunction

endpackage

// File: rtl/amb_sample_store.sv
module amb_sample_store #(
    parameter int DEPTH  = 64,
    parameter int SAMP_W = 12,
    localparam int AW    = amb_sweep_pkg::clog2_min1(DEPTH)
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [AW-1:0]            waddr,
    input  logic signed [SAMP_W-1:0] wi,
    input  logic signed [SAMP_W-1:0] wq,
    input  logic [AW-1:0]            raddr,
    output logic signed [SAMP_W-1:0] ri,
    output logic signed [SAMP_W-1:0] rq
);
    logic [2*SAMP_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= {wi, wq};
        end
        {ri, rq} <= mem[raddr];
    end
endmodule

// File: rtl/amb_sweep_seq.sv
module amb_sweep_seq
    import amb_sweep_pkg::*;
#(
    parameter int REF_LEN     = 64,
    parameter int NUM_OFFSETS = 8,
    parameter int PHASE_W     = 16,
    localparam int LAG_W      = $clog2(REF_LEN),
    localparam int OFF_W      = clog2_min1(NUM_OFFSETS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               off_we,
    input  logic [OFF_W-1:0]   off_waddr,
    input  logic [PHASE_W-1:0] off_winc,
    input  logic               fin_seen,
    output mac_ctl_t           iss_ctl,
    output logic [OFF_W-1:0]   iss_off,
    output logic [LAG_W-1:0]   iss_lag,
    output logic [LAG_W-1:0]   ref_raddr,
    output logic [LAG_W:0]     cap_raddr
);
    sweep_state_e       state;
    logic [LAG_W-1:0]   k_cnt;
    logic [LAG_W-1:0]   lag_cnt;
    logic [OFF_W-1:0]   off_cnt;
    logic [PHASE_W-1:0] inc_tab [NUM_OFFSETS];

    logic               k_last, lag_last, off_last, fin_term;
    logic [LAG_W:0]     cap_idx;
    logic [PHASE_W-1:0] cap_idx_ph;
    logic [PHASE_W-1:0] phase;

    always_ff @(posedge clk) begin
        if (off_we) begin
            inc_tab[off_waddr] <= off_winc;
        end
    end

    always_comb begin
        k_last     = (k_cnt == LAG_W'(REF_LEN - 1));
        lag_last   = (lag_cnt == LAG_W'(REF_LEN - 1));
        off_last   = (off_cnt == OFF_W'(NUM_OFFSETS - 1));
        fin_term   = k_last && lag_last && off_last;
        cap_idx    = (LAG_W+1)'(k_cnt) + (LAG_W+1)'(lag_cnt);
        cap_idx_ph = PHASE_W'(cap_idx);
        phase      = cap_idx_ph * inc_tab[off_cnt];

        iss_ctl.vld   = (state == SW_RUN);
        iss_ctl.first = (k_cnt == '0);
        iss_ctl.last  = k_last;
        iss_ctl.fin   = fin_term;
        iss_ctl.quad  = phase[PHASE_W-1 -: QUAD_W];

        iss_off   = off_cnt;
        iss_lag   = lag_cnt;
        ref_raddr = k_cnt;
        cap_raddr = cap_idx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SW_IDLE;
            k_cnt   <= '0;
            lag_cnt <= '0;
            off_cnt <= '0;
        end else begin
            unique case (state)
                SW_IDLE: begin
                    if (start) begin
                        state   <= SW_RUN;
                        k_cnt   <= '0;
                        lag_cnt <= '0;
                        off_cnt <= '0;
                    end
                end
                SW_RUN: begin
                    k_cnt <= k_last ? '0 : k_cnt + 1'b1;
                    if (k_last) begin
                        lag_cnt <= lag_last ? '0 : lag_cnt + 1'b1;
                        if (lag_last) begin
                            off_cnt <= off_last ? '0 : off_cnt + 1'b1;
                        end
                    end
                    if (fin_term) begin
                        state <= SW_DRAIN;
                    end
                end
                SW_DRAIN: begin
                    if (fin_seen) begin
                        state <= SW_IDLE;
                    end
                end
                default: state <= SW_IDLE;
            endcase
        end
    end

    // R9: a start during a run never rewinds the counters to the first term
    p_start_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        (state == SW_RUN && start && !fin_term) |=>
        !(state == SW_RUN && k_cnt == '0 && lag_cnt == '0 && off_cnt == '0));

    // R2: offset index only moves at the end of a lag row
    p_off_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (state == SW_RUN && !(k_last && lag_last)) |=> (off_cnt == $past(off_cnt)));
endmodule

// File: rtl/amb_cmac_stage.sv
module amb_cmac_stage
    import amb_sweep_pkg::*;
#(
    parameter int SAMP_W  = 12,
    parameter int REF_LEN = 64,
    localparam int PROD_W = 2*SAMP_W + 2,
    localparam int ACC_W  = PROD_W + $clog2(REF_LEN)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  mac_ctl_t                 in_ctl,
    input  logic signed [SAMP_W-1:0] ref_i,
    input  logic signed [SAMP_W-1:0] ref_q,
    input  logic signed [SAMP_W-1:0] cap_i,
    input  logic signed [SAMP_W-1:0] cap_q,
    output logic                     acc_emit,
    output logic                     acc_fin,
    output logic signed [ACC_W-1:0]  acc_i,
    output logic signed [ACC_W-1:0]  acc_q
);
    logic signed [SAMP_W:0]   ext_i, ext_q, rot_i, rot_q;
    logic signed [PROD_W-1:0] rx_i, rx_q, cx_i, cx_q;
    logic signed [PROD_W-1:0] prod_i, prod_q;
    logic signed [PROD_W-1:0] s2_pi, s2_pq;
    mac_ctl_t                 s2_ctl;

    // exact quarter-turn rotation, one guard bit absorbs the negation of the minimum
    always_comb begin
        ext_i = (SAMP_W+1)'(cap_i);
        ext_q = (SAMP_W+1)'(cap_q);
        unique case (in_ctl.quad)
            2'd0:    begin rot_i =  ext_i; rot_q =  ext_q; end
            2'd1:    begin rot_i = -ext_q; rot_q =  ext_i; end
            2'd2:    begin rot_i = -ext_i; rot_q = -ext_q; end
            default: begin rot_i =  ext_q; rot_q = -ext_i; end
        endcase
        rx_i   = PROD_W'(ref_i);
        rx_q   = PROD_W'(ref_q);
        cx_i   = PROD_W'(rot_i);
        cx_q   = PROD_W'(rot_q);
        // conj(ref) * rotated capture
        prod_i = rx_i * cx_i + rx_q * cx_q;
        prod_q = rx_i * cx_q - rx_q * cx_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s2_ctl <= '0;
            s2_pi  <= '0;
            s2_pq  <= '0;
        end else begin
            s2_ctl <= in_ctl;
            s2_pi  <= prod_i;
            s2_pq  <= prod_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_i    <= '0;
            acc_q    <= '0;
            acc_emit <= 1'b0;
            acc_fin  <= 1'b0;
        end else begin
            acc_emit <= s2_ctl.vld && s2_ctl.last;
            acc_fin  <= s2_ctl.vld && s2_ctl.fin;
            if (s2_ctl.vld) begin
                if (s2_ctl.first) begin
                    acc_i <= ACC_W'(s2_pi);
                    acc_q <= ACC_W'(s2_pq);
                end else begin
                    acc_i <= acc_i + ACC_W'(s2_pi);
                    acc_q <= acc_q + ACC_W'(s2_pq);
                end
            end
        end
    end

    // R4: terms of one lag arrive on consecutive cycles
    p_acc_chain_r4: assert property (@(posedge clk) disable iff (rst)
        (s2_ctl.vld && !s2_ctl.first) |-> $past(s2_ctl.vld));
endmodule

// File: rtl/amb_sweep_ctrl.sv
module amb_sweep_ctrl
    import amb_sweep_pkg::*;
#(
    parameter int REF_LEN     = 64,
    parameter int NUM_OFFSETS = 8,
    parameter int SAMP_W      = 12,
    parameter int PHASE_W     = 16,
    localparam int CAP_LEN    = 2 * REF_LEN,
    localparam int LAG_W      = $clog2(REF_LEN),
    localparam int OFF_W      = clog2_min1(NUM_OFFSETS),
    localparam int PROD_W     = 2*SAMP_W + 2,
    localparam int ACC_W      = PROD_W + LAG_W,
    localparam int MAG_W      = 2 * ACC_W,
    localparam int TAG_W      = OFF_W + LAG_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     ref_we,
    input  logic [LAG_W-1:0]         ref_waddr,
    input  logic signed [SAMP_W-1:0] ref_wi,
    input  logic signed [SAMP_W-1:0] ref_wq,
    input  logic                     cap_we,
    input  logic [LAG_W:0]           cap_waddr,
    input  logic signed [SAMP_W-1:0] cap_wi,
    input  logic signed [SAMP_W-1:0] cap_wq,
    input  logic                     off_we,
    input  logic [OFF_W-1:0]         off_waddr,
    input  logic [PHASE_W-1:0]       off_winc,
    input  logic                     start,
    output logic                     res_valid,
    output logic [OFF_W-1:0]         res_off,
    output logic signed [LAG_W-1:0]  res_lag,
    output logic [MAG_W-1:0]         res_mag,
    output logic                     done
);
    mac_ctl_t                 s0_ctl, s1_ctl;
    logic [OFF_W-1:0]         s0_off;
    logic [LAG_W-1:0]         s0_lag;
    logic [LAG_W-1:0]         ref_raddr;
    logic [LAG_W:0]           cap_raddr;
    logic signed [SAMP_W-1:0] rd_ref_i, rd_ref_q, rd_cap_i, rd_cap_q;
    logic [TAG_W-1:0]         tag_s1, tag_s2, tag_s3;
    logic                     acc_emit, acc_fin;
    logic signed [ACC_W-1:0]  acc_i, acc_q;
    logic signed [MAG_W-1:0]  sq_i, sq_q;
    logic                     res_fin;
    logic                     fin_seen;

    assign fin_seen = res_valid && res_fin;

    amb_sweep_seq #(
        .REF_LEN(REF_LEN), .NUM_OFFSETS(NUM_OFFSETS), .PHASE_W(PHASE_W)
    ) u_seq (
        .clk(clk), .rst(rst), .start(start),
        .off_we(off_we), .off_waddr(off_waddr), .off_winc(off_winc),
        .fin_seen(fin_seen),
        .iss_ctl(s0_ctl), .iss_off(s0_off), .iss_lag(s0_lag),
        .ref_raddr(ref_raddr), .cap_raddr(cap_raddr)
    );

    amb_sample_store #(.DEPTH(REF_LEN), .SAMP_W(SAMP_W)) u_ref_store (
        .clk(clk), .we(ref_we), .waddr(ref_waddr), .wi(ref_wi), .wq(ref_wq),
        .raddr(ref_raddr), .ri(rd_ref_i), .rq(rd_ref_q)
    );

    amb_sample_store #(.DEPTH(CAP_LEN), .SAMP_W(SAMP_W)) u_cap_store (
        .clk(clk), .we(cap_we), .waddr(cap_waddr), .wi(cap_wi), .wq(cap_wq),
        .raddr(cap_raddr), .ri(rd_cap_i), .rq(rd_cap_q)
    );

    // control and tags follow the synchronous read, then the two MAC stages
    always_ff @(posedge clk) begin
        if (rst) begin
            s1_ctl <= '0;
            tag_s1 <= '0;
            tag_s2 <= '0;
            tag_s3 <= '0;
        end else begin
            s1_ctl <= s0_ctl;
            tag_s1 <= {s0_off, s0_lag};
            tag_s2 <= tag_s1;
            tag_s3 <= tag_s2;
        end
    end

    amb_cmac_stage #(.SAMP_W(SAMP_W), .REF_LEN(REF_LEN)) u_cmac (
        .clk(clk), .rst(rst), .in_ctl(s1_ctl),
        .ref_i(rd_ref_i), .ref_q(rd_ref_q), .cap_i(rd_cap_i), .cap_q(rd_cap_q),
        .acc_emit(acc_emit), .acc_fin(acc_fin), .acc_i(acc_i), .acc_q(acc_q)
    );

    always_comb begin
        sq_i = MAG_W'(acc_i) * MAG_W'(acc_i);
        sq_q = MAG_W'(acc_q) * MAG_W'(acc_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_fin   <= 1'b0;
            res_off   <= '0;
            res_lag   <= '0;
            res_mag   <= '0;
            done      <= 1'b0;
        end else begin
            res_valid <= acc_emit;
            res_fin   <= acc_emit && acc_fin;
            done      <= fin_seen;
            if (acc_emit) begin
                res_off <= tag_s3[TAG_W-1 -: OFF_W];
                res_lag <= tag_s3[LAG_W-1:0] - LAG_W'(REF_LEN / 2);
                res_mag <= MAG_W'(sq_i + sq_q);
            end
        end
    end

    // R8: the final result is followed by done on the next cycle
    p_done_after_final_r8: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_fin) |=> done);

    // R8: done never lasts two cycles
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10: results are never back to back
    p_res_gap_r10: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid);
endmodule

// File: tb/amb_sweep_ctrl_tb.sv
module amb_sweep_ctrl_tb_top;
    localparam int N     = 8;
    localparam int NO    = 4;
    localparam int SW    = 6;
    localparam int PW    = 4;
    localparam int LW    = $clog2(N);
    localparam int OW    = 2;
    localparam int MW    = 2 * (2*SW + 2 + LW);
    localparam int WDOG  = 20000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_we = 1'b0, cap_we = 1'b0, off_we = 1'b0, start = 1'b0;
    logic [LW-1:0] ref_waddr = '0;
    logic [LW:0]   cap_waddr = '0;
    logic [OW-1:0] off_waddr = '0;
    logic signed [SW-1:0] ref_wi = '0, ref_wq = '0, cap_wi = '0, cap_wq = '0;
    logic [PW-1:0] off_winc = '0;
    logic res_valid, done;
    logic [OW-1:0] res_off;
    logic signed [LW-1:0] res_lag;
    logic [MW-1:0] res_mag;

    int checks = 0;
    int fails  = 0;
    int r_i [N], r_q [N], c_i [2*N], c_q [2*N], incs [NO];

    always #10 clk = ~clk;

    amb_sweep_ctrl #(.REF_LEN(N), .NUM_OFFSETS(NO), .SAMP_W(SW), .PHASE_W(PW)) dut_i (
        .clk(clk), .rst(rst),
        .ref_we(ref_we), .ref_waddr(ref_waddr), .ref_wi(ref_wi), .ref_wq(ref_wq),
        .cap_we(cap_we), .cap_waddr(cap_waddr), .cap_wi(cap_wi), .cap_wq(cap_wq),
        .off_we(off_we), .off_waddr(off_waddr), .off_winc(off_winc),
        .start(start), .res_valid(res_valid), .res_off(res_off), .res_lag(res_lag),
        .res_mag(res_mag), .done(done)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint model_mag(input int o, input int m);
        longint si = 0, sq = 0;
        for (int k = 0; k < N; k++) begin
            int n  = k + m;
            int ph = ((n * incs[o]) % (1 << PW) + (1 << PW)) % (1 << PW);
            int q  = ph >> (PW - 2);
            int yi, yq;
            case (q)
                0: begin yi =  c_i[n]; yq =  c_q[n]; end
                1: begin yi = -c_q[n]; yq =  c_i[n]; end
                2: begin yi = -c_i[n]; yq = -c_q[n]; end
                default: begin yi = c_q[n]; yq = -c_i[n]; end
            endcase
            si += r_i[k] * yi + r_q[k] * yq;
            sq += r_i[k] * yq - r_q[k] * yi;
        end
        return si * si + sq * sq;
    endfunction

    task automatic load_set(input int seed, input int i0, input int i1, input int i2, input int i3);
        incs[0] = i0; incs[1] = i1; incs[2] = i2; incs[3] = i3;
        for (int k = 0; k < N; k++) begin
            r_i[k] = ((k * 37 + seed * 11 + 5) % 64) - 32;
            r_q[k] = ((k * 53 + seed * 7 + 19) % 64) - 32;
            @(negedge clk);
            ref_we = 1'b1; ref_waddr = LW'(k);
            ref_wi = SW'(r_i[k]); ref_wq = SW'(r_q[k]);
        end
        for (int n = 0; n < 2*N; n++) begin
            c_i[n] = ((n * 29 + seed * 13 + 3) % 64) - 32;
            c_q[n] = ((n * 45 + seed * 5 + 40) % 64) - 32;
            @(negedge clk);
            ref_we = 1'b0;
            cap_we = 1'b1; cap_waddr = (LW+1)'(n);
            cap_wi = SW'(c_i[n]); cap_wq = SW'(c_q[n]);
        end
        for (int o = 0; o < NO; o++) begin
            @(negedge clk);
            cap_we = 1'b0;
            off_we = 1'b1; off_waddr = OW'(o); off_winc = PW'(incs[o]);
        end
        @(negedge clk);
        off_we = 1'b0;
    endtask

    task automatic run_sweep(input bit restart_mid);
        int cyc = 0, eo = 0, el = 0, got = 0, last = -1;
        bit fin = 0;
        @(negedge clk);
        start = 1'b1;
        while (!fin && cyc < WDOG) begin
            @(negedge clk);
            cyc++;
            start = (restart_mid && cyc == 3*N) ? 1'b1 : 1'b0;
            if (res_valid) begin
                chk(res_off == OW'(eo), "R2 offset order", res_off, eo);
                chk(res_lag == LW'(el - N/2), "R3 signed lag", res_lag, el - N/2);
                // R4 R5 R6 R7: correlation of rotated capture, squared magnitude
                chk(res_mag == MW'(model_mag(eo, el)),
                    incs[eo] < 0 ? "R7 magnitude" : "R4 R5 R6 magnitude",
                    res_mag, model_mag(eo, el));
                if (last >= 0) chk(cyc - last == N, "R10 spacing", cyc - last, N);
                last = cyc;
                got++;
                if (el == N-1) begin el = 0; eo++; end else el++;
            end
            if (done) begin
                chk(last == cyc - 1, "R8 done timing", cyc - last, 1);
                chk(got == N*NO, "R2 result count", got, N*NO);
                fin = 1;
            end
        end
        start = 1'b0;
        chk(fin, "R8 watchdog", cyc, WDOG);
    endtask

    task automatic quiet_window(input string req);
        int noise = 0;
        for (int c = 0; c < 3*N; c++) begin
            @(negedge clk);
            if (res_valid || done) noise++;
        end
        chk(noise == 0, req, noise, 0);
    endtask

    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL global watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        chk(res_valid == 1'b0, "R1 reset valid", res_valid, 0);
        chk(done == 1'b0, "R1 reset done", done, 0);
        quiet_window("R1 idle without start");
        load_set(1, 0, 4, -4, 3);
        run_sweep(1'b0);
        quiet_window("R8 single done");
        load_set(2, -1, 8, 6, -7);
        run_sweep(1'b1);
        quiet_window("R9 mid-sweep start ignored");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule